// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous on-chip requester and an external 512K x 8 asynchronous static RAM whose chip select, output enable and write enable lines are all active low. The requester hands over one byte-wide read or write at a time through a valid/ready handshake. The controller then plays out the strobe sequence the memory needs and, for reads, returns the byte with a one-cycle response pulse. The bidirectional memory data bus appears as three separate signals: drive value, sampled value and drive enable.

Every phase length is derived from the memory's timing minimums in picoseconds and a clock-period parameter. Each minimum is divided by the period and rounded up, and no phase lasts less than one cycle. With the defaults (5 ns clock, faster speed grade) a read holds the strobes for 11 cycles. A write uses 1 setup cycle, then 9 cycles of write-enable low, then 1 recovery cycle. The turnaround after a read is 4 cycles. A standby input parks the idle memory deselected.

The state machine has seven states. IDLE waits for a request with chip select low and outputs disabled. SLEEP is the deselected standby state. RD_ACCESS holds the read strobes. RD_TURN gives the memory time to release the bus. WR_SETUP drives chip select, address and data with write enable still high. WR_PULSE holds write enable low. WR_RECOVER raises write enable while address and data are still held. The transitions are as follows. IDLE goes to RD_ACCESS or WR_SETUP on an accepted request, and to SLEEP when standby is set and no request is present. SLEEP returns to IDLE on a request or when standby clears. RD_ACCESS goes to RD_TURN, and RD_TURN to IDLE. WR_SETUP goes to WR_PULSE, WR_PULSE to WR_RECOVER, and WR_RECOVER to IDLE. Each of these last five moves happens when the phase count runs out.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is asserted, output enable and write enable are high, the data drivers are off and no response pulse is produced.
- R2: `req_ready` is high only in IDLE, where output enable and write enable are high and the drivers are off; a request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is low on the next cycle.
- R3: A read holds chip select and output enable low with write enable high for exactly max(ceil(tRC), ceil(tAA), ceil(tCO)) cycles (11 at defaults). The data bus is sampled at the end of the last of those cycles, and `rsp_valid` is then high for exactly one cycle carrying that byte.
- R4: A write is write-enable controlled with output enable high throughout. Chip select and the drivers turn on first for ceil(tAS) cycles (1 at defaults) with write enable high. Write enable is then low for max(ceil(tWP), ceil(tDW), ceil(tAW)) cycles (9 at defaults). Write enable then rises and the drivers stay on for max(1, ceil(tWR), ceil(tWC) minus the two earlier phases) cycles (1 at defaults).
- R5: Address and write data on the memory side stay unchanged from the first to the last cycle of an access, including the recovery cycle after write enable rises.
- R6: The data drivers are never enabled while output enable is low.
- R7: After output enable rises at the end of a read, at least ceil(tHZ) cycles (4 at defaults) pass before the drivers are enabled again.
- R8: With standby set and no request present, the controller enters SLEEP one cycle after IDLE. In SLEEP chip select is high, all strobes are high, the drivers are off and `req_ready` is low. A request or the release of standby returns it to IDLE on the next cycle, where chip select is low and outputs stay disabled.
- R9: A read returns the byte most recently written to the same address, across the full address range including address 0 and the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Park the idle memory deselected |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_in | input | 8 | Value sampled from the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The properties assume that the requester keeps `req_write`, `req_addr` and `req_wdata` steady while `req_valid` waits for `req_ready`. They also assume that the memory model puts valid data on `mem_dq_in` only once a full access time has passed with output enable low. The bench drives every request field at a falling edge and holds it until the edge that takes the request. Its memory model returns a poison byte until output enable has been low for the full read count, so a controller that samples early returns the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctrl_state_t;

    // Round a time up to whole clock cycles, never below one.
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 11,
    parameter int TA_CYC  = 4,
    parameter int AS_CYC  = 1,
    parameter int WP_CYC  = 9,
    parameter int WR_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    ctrl_state_t state_q, state_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid)    state_n = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
                else if (standby) state_n = ST_SLEEP;
            end
            ST_SLEEP:      if (req_valid || !standby) state_n = ST_IDLE;
            ST_RD_ACCESS:  if (expired) state_n = ST_RD_TURN;
            ST_RD_TURN:    if (expired) state_n = ST_IDLE;
            ST_WR_SETUP:   if (expired) state_n = ST_WR_PULSE;
            ST_WR_PULSE:   if (expired) state_n = ST_WR_RECOVER;
            ST_WR_RECOVER: if (expired) state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // Phase length loaded on entry to each timed state
    always_comb begin
        load     = (state_n != state_q);
        load_val = '0;
        unique case (state_n)
            ST_RD_ACCESS:  load_val = CNT_W'(RD_CYC - 1);
            ST_RD_TURN:    load_val = CNT_W'(TA_CYC - 1);
            ST_WR_SETUP:   load_val = CNT_W'(AS_CYC - 1);
            ST_WR_PULSE:   load_val = CNT_W'(WP_CYC - 1);
            ST_WR_RECOVER: load_val = CNT_W'(WR_CYC - 1);
            default:       load_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        cs_n      = 1'b0;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        dq_oe     = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:       req_ready = 1'b1;
            ST_SLEEP:      cs_n = 1'b1;
            ST_RD_ACCESS:  oe_n = 1'b0;
            ST_RD_TURN:    ;
            ST_WR_SETUP:   dq_oe = 1'b1;
            ST_WR_PULSE: begin
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_RECOVER: dq_oe = 1'b1;
            default:       cs_n = 1'b1;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_ACCESS) && expired;

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= capture;
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rsp_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 5000,
    parameter int T_RC_PS  = 55000,
    parameter int T_AA_PS  = 55000,
    parameter int T_CO_PS  = 55000,
    parameter int T_WC_PS  = 55000,
    parameter int T_WP_PS  = 40000,
    parameter int T_AW_PS  = 45000,
    parameter int T_DW_PS  = 25000,
    parameter int T_AS_PS  = 0,
    parameter int T_WR_PS  = 0,
    parameter int T_HZ_PS  = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC = max_of(max_of(cycles_for(T_RC_PS, CLK_PS),
                                          cycles_for(T_AA_PS, CLK_PS)),
                                   cycles_for(T_CO_PS, CLK_PS));
    localparam int TA_CYC = cycles_for(T_HZ_PS, CLK_PS);
    localparam int AS_CYC = cycles_for(T_AS_PS, CLK_PS);
    localparam int WP_CYC = max_of(max_of(cycles_for(T_WP_PS, CLK_PS),
                                          cycles_for(T_DW_PS, CLK_PS)),
                                   cycles_for(T_AW_PS, CLK_PS));
    localparam int WR_CYC = max_of(max_of(1, cycles_for(T_WR_PS, CLK_PS)),
                                   cycles_for(T_WC_PS, CLK_PS) - AS_CYC - WP_CYC);
    localparam int CNT_MAX = max_of(max_of(RD_CYC, TA_CYC),
                                    max_of(max_of(AS_CYC, WP_CYC), WR_CYC));
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             capture;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_ctrl_fsm #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .TA_CYC (TA_CYC),
        .AS_CYC (AS_CYC),
        .WP_CYC (WP_CYC),
        .WR_CYC (WR_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_io_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_dq_oe));

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    assert_pulse_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    assert_recover_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

    assert_single_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_done_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_oe_n && mem_we_n && !mem_dq_oe && !mem_cs_n));

    assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready));

endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_access_ctrl_tb.sv
module sram_access_ctrl_tb;

    localparam int RD_EXP = 11;
    localparam int AS_EXP = 1;
    localparam int WP_EXP = 9;
    localparam int WR_EXP = 1;
    localparam int TA_EXP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [7:0] ref_mem [int];
    logic [7:0] bus_mem [int];
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    sram_access_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        ref_mem[int'(a)] = d;
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [18:0] a);
        exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
        issue(1'b0, a, 8'h00);
    endtask

    // Monitor and memory model, sampled at the falling edge
    logic p_oe_n = 1, p_we_n = 1, p_dq_oe = 0, p_rsp = 0;
    logic [18:0] p_addr = '0;
    logic [7:0]  p_dout = '0;
    int rd_len = 0, we_len = 0, setup_len = 0, rec_len = 0, since_oe = 1000;
    bit  after_pulse = 0, read_seen = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) chk(0, "R6 drivers on with OE low", 1, 0);
            if (!mem_oe_n && (mem_cs_n || !mem_we_n)) chk(0, "R3 read strobes", mem_cs_n, 0);
            if (!mem_we_n && (!mem_oe_n || mem_cs_n || !mem_dq_oe)) chk(0, "R4 write strobes", mem_oe_n, 1);
            if (mem_dq_oe && p_dq_oe && (mem_addr != p_addr || mem_dq_out != p_dout))
                chk(0, "R5 write hold", int'(mem_addr), int'(p_addr));
            if (!mem_oe_n && !p_oe_n && mem_addr != p_addr)
                chk(0, "R5 read hold", int'(mem_addr), int'(p_addr));
            // read length and data availability
            if (!mem_oe_n) rd_len++;
            else if (!p_oe_n) begin
                chk(rd_len == RD_EXP, "R3 read strobe length", rd_len, RD_EXP);
                rd_len = 0;
                since_oe = 0;
                read_seen = 1;
            end
            if (since_oe < 1000) since_oe++;
            // write phases
            if (!mem_we_n) begin
                if (p_we_n) chk(setup_len == AS_EXP, "R4 setup length", setup_len, AS_EXP);
                we_len++;
                bus_mem[int'(mem_addr)] = mem_dq_out;
            end else if (!p_we_n) begin
                chk(we_len == WP_EXP, "R4 write pulse length", we_len, WP_EXP);
                we_len = 0;
                after_pulse = 1;
                rec_len = 0;
            end
            if (mem_dq_oe && mem_we_n && !after_pulse) setup_len++;
            if (mem_dq_oe && mem_we_n && after_pulse) rec_len++;
            if (!mem_dq_oe && p_dq_oe) begin
                chk(rec_len == WR_EXP, "R4 recovery length", rec_len, WR_EXP);
                after_pulse = 0;
                setup_len = 0;
            end
            if (mem_dq_oe && !p_dq_oe && read_seen) begin
                chk(since_oe >= TA_EXP, "R7 turnaround", since_oe, TA_EXP);
                read_seen = 0;
            end
            // scoreboard
            if (rsp_valid) begin
                chk(!p_rsp, "R3 done pulse width", 2, 1);
                if (exp_q.size() == 0) chk(0, "R3 unexpected done", 1, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R9 read data", rsp_rdata, e);
                end
            end
        end
        // bus returns poison until a full access time has elapsed
        if (!mem_cs_n && !mem_oe_n && rd_len >= RD_EXP)
            mem_dq_in <= bus_mem.exists(int'(mem_addr)) ? bus_mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in <= 8'hEE;
        p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe; p_rsp = rsp_valid;
        p_addr = mem_addr; p_dout = mem_dq_out;
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        wait (cyc > 100000);
        chk(0, "watchdog expired", cyc, 100000);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_oe_n, mem_we_n}, 3);
        chk(!mem_dq_oe && !rsp_valid, "R1 quiet in reset", {mem_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_cs_n && mem_oe_n, "R2 idle after reset", {req_ready, mem_cs_n}, 2);

        // ready drops after a request is taken
        exp_q.push_back(8'h00);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 19'h00123;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        repeat (20) @(negedge clk);

        do_write(19'h00000, 8'hA5);
        do_write(19'h7FFFF, 8'h3C);
        do_write(19'h12345, 8'hFF);
        do_write(19'h12345, 8'h5A);
        do_read(19'h00000);
        do_read(19'h7FFFF);
        do_write(19'h00010, 8'h81);
        do_read(19'h12345);
        do_read(19'h00010);
        do_read(19'h40000);
        for (int i = 0; i < 6; i++) do_write(19'(i * 4099), 8'(i * 37 + 1));
        for (int i = 5; i >= 0; i--) do_read(19'(i * 4099));
        repeat (20) @(negedge clk);

        // standby
        standby = 1;
        @(negedge clk);
        @(negedge clk);
        chk(mem_cs_n && !req_ready, "R8 deselected in standby", {mem_cs_n, req_ready}, 2);
        chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R8 strobes in standby", mem_dq_oe, 0);
        do_read(19'h7FFFF);
        repeat (25) @(negedge clk);
        chk(mem_cs_n, "R8 back to standby", mem_cs_n, 1);
        standby = 0;
        @(negedge clk);
        @(negedge clk);
        chk(!mem_cs_n && mem_oe_n && req_ready, "R8 wake to idle", {mem_cs_n, req_ready}, 1);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
        finish_run();
    end

endmodule